// File: doc/BRIEF.md
# Programmable Start-Up Event Sequencer

Once a device has finished loading its configuration, three events still have to happen before the logic is in use. The DONE pad is released high, the user I/O buffers are enabled, and the internal core reset is removed. This block produces those three releases. Each one is tied to a programmable step of a short step counter. The events can therefore come in any order, several of them can share a step, and the whole sequence takes only a few clock cycles. The configuration logic raises a completion level, and the sequencer then advances one step per clock edge. No bitstream-length bookkeeping is involved.

The sequencer runs from a selected clock: either the configuration clock or a user-supplied clock, chosen by a static option. When the wait option is set, the sequencer watches the open-drain DONE pad after it has released DONE. While anything outside the device holds that pad low, the counter waits one step past the DONE release. This lets a board delay the remaining events until every device sharing the DONE line is ready. All three outputs are sticky and clear only on the asynchronous reprogram reset.

Top module: `startup_seq`

## Requirements
- R1: While `rst_n` is low, `done_rel`, `io_en` and `core_reset_off` are all low. A reset in the middle of a run clears them again.
- R2: While `load_done` is low, the step counter does not advance and no output rises.
- R3: `load_done` passes through a 2-stage synchronizer on the selected clock. On the 3rd selected-clock edge after `load_done` rises, the counter reaches step 1. From then on it moves up by exactly one step per edge.
- R4: Each event has a 2-bit code c (c = 0 to 3). The event fires on the edge where the counter reaches step c+1. The three codes are independent, so any order is possible, and events with equal codes fire on the same edge.
- R5: Once an output is high, it stays high until `rst_n` is low. Changing the codes or dropping `load_done` after the event has fired has no effect on it.
- R6: With `use_user_clk`=1, the sequencer counts edges of `clk_user` only. With `use_user_clk`=0, it counts edges of `clk_cfg` only.
- R7: With `wait_on_done`=1, the counter does not go past step `done_step`+2 while the DONE pad reads low. After the pad goes high, the counter resumes on the 3rd selected-clock edge (2-stage pad synchronizer).
- R8: With `wait_on_done`=0, the level on `done_pad_in` has no effect on the sequence.
- R9: The counter saturates at step 4. After that, all three outputs are high and remain high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cfg | input | 1 | Configuration clock |
| clk_user | input | 1 | User clock, an optional sequencing clock |
| rst_n | input | 1 | Asynchronous active-low reprogram reset |
| use_user_clk | input | 1 | 1 selects `clk_user` as the sequencing clock |
| load_done | input | 1 | Configuration loading complete (level) |
| wait_on_done | input | 1 | 1 stalls after the DONE release until the pad reads high |
| done_step | input | 2 | Step code for the DONE release |
| io_step | input | 2 | Step code for the I/O enable |
| rst_step | input | 2 | Step code for the core reset release |
| done_pad_in | input | 1 | Level read back from the open-drain DONE pad |
| done_rel | output | 1 | Releases the DONE pad (1 = stop pulling low) |
| io_en | output | 1 | Enables the user I/O buffers |
| core_reset_off | output | 1 | Deasserts the internal global reset |

## Verification
A step counter that has slipped shows up at once as an output rising one edge early or late relative to its programmed code. A lost sticky flag shows up as an output falling while the block is not in reset. A stall condition that is wrong is visible within three selected-clock edges after the DONE pad changes: either the later events fire while the pad is still held low, or they stay low after it is released. A clock-select fault makes the event timing track the wrong clock, so the outputs run ahead of the user-clock edge count after only a couple of edges.

// File: rtl/startup_seq_pkg.sv
package startup_seq_pkg;
   typedef enum int unsigned {
      EV_DONE = 0,
      EV_IO   = 1,
      EV_RST  = 2
   } sup_event_e;

   localparam int unsigned NUM_EVT = 3;
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[s] <= '0;
         else        stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/sup_clk_sel.sv
module sup_clk_sel #(
   parameter bit USER_CLK_OPT = 1'b1
) (
   input  logic clk_cfg,
   input  logic clk_user,
   input  logic sel_user,
   output logic clk_out
);
   if (USER_CLK_OPT) begin : g_mux
      assign clk_out = sel_user ? clk_user : clk_cfg;
   end else begin : g_fixed
      logic unused_sel;
      assign unused_sel = sel_user ^ clk_user;
      assign clk_out    = clk_cfg;
   end
endmodule

// File: rtl/sup_step_ctr.sv
module sup_step_ctr #(
   parameter int unsigned NUM_STEPS = 4,
   parameter int unsigned STEP_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              hold,
   output logic [STEP_W-1:0] cnt_q,
   output logic [STEP_W-1:0] cnt_d
);
   localparam logic [STEP_W-1:0] LAST = STEP_W'(NUM_STEPS);

   always_comb begin
      cnt_d = cnt_q;
      if (run && !hold && (cnt_q < LAST)) cnt_d = cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end
endmodule

// File: rtl/sup_evt_latch.sv
module sup_evt_latch #(
   parameter int unsigned STEP_W = 3,
   parameter int unsigned CODE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STEP_W-1:0] cnt_d,
   input  logic [CODE_W-1:0] code,
   output logic              fired_q
);
   logic reach;

   assign reach = (cnt_d > STEP_W'(code));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fired_q <= 1'b0;
      else        fired_q <= fired_q | reach;
   end
endmodule

// File: rtl/startup_seq.sv
module startup_seq
   import startup_seq_pkg::*;
#(
   parameter int unsigned NUM_STEPS    = 4,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter bit          USER_CLK_OPT = 1'b1,
   localparam int unsigned CODE_W      = $clog2(NUM_STEPS)
) (
   input  logic              clk_cfg,
   input  logic              clk_user,
   input  logic              rst_n,
   input  logic              use_user_clk,
   input  logic              load_done,
   input  logic              wait_on_done,
   input  logic [CODE_W-1:0] done_step,
   input  logic [CODE_W-1:0] io_step,
   input  logic [CODE_W-1:0] rst_step,
   input  logic              done_pad_in,
   output logic              done_rel,
   output logic              io_en,
   output logic              core_reset_off
);
   localparam int unsigned STEP_W = $clog2(NUM_STEPS + 2);

   if (NUM_STEPS < 2) begin : g_bad_steps
      $error("startup_seq: NUM_STEPS must be at least 2");
   end
   if ((NUM_STEPS & (NUM_STEPS - 1)) != 0) begin : g_bad_pow2
      $error("startup_seq: NUM_STEPS must be a power of two");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("startup_seq: SYNC_STAGES must be at least 2");
   end

   logic              clk_sel;
   logic              ld_sync;
   logic              pad_sync;
   logic              hold;
   logic [STEP_W-1:0] cnt_q;
   logic [STEP_W-1:0] cnt_d;
   logic [CODE_W-1:0] codes [NUM_EVT];
   logic [NUM_EVT-1:0] fired;

   sup_clk_sel #(.USER_CLK_OPT(USER_CLK_OPT)) u_clk_sel (
      .clk_cfg (clk_cfg),
      .clk_user(clk_user),
      .sel_user(use_user_clk),
      .clk_out (clk_sel)
   );

   sup_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk_sel),
      .rst_n(rst_n),
      .d    ({load_done, done_pad_in}),
      .q    ({ld_sync, pad_sync})
   );

   // Stall one step past the DONE release while the pad is held low.
   assign hold = wait_on_done && !pad_sync &&
                 (cnt_q >= (STEP_W'(done_step) + STEP_W'(2)));

   sup_step_ctr #(.NUM_STEPS(NUM_STEPS), .STEP_W(STEP_W)) u_ctr (
      .clk  (clk_sel),
      .rst_n(rst_n),
      .run  (ld_sync),
      .hold (hold),
      .cnt_q(cnt_q),
      .cnt_d(cnt_d)
   );

   assign codes[EV_DONE] = done_step;
   assign codes[EV_IO]   = io_step;
   assign codes[EV_RST]  = rst_step;

   for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
      sup_evt_latch #(.STEP_W(STEP_W), .CODE_W(CODE_W)) u_latch (
         .clk    (clk_sel),
         .rst_n  (rst_n),
         .cnt_d  (cnt_d),
         .code   (codes[e]),
         .fired_q(fired[e])
      );
   end

   assign done_rel       = fired[EV_DONE];
   assign io_en          = fired[EV_IO];
   assign core_reset_off = fired[EV_RST];
endmodule

// File: rtl/startup_seq_chk.sv
module startup_seq_chk #(
   parameter int unsigned NUM_STEPS = 4,
   parameter int unsigned STEP_W    = 3,
   parameter int unsigned CODE_W    = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [STEP_W-1:0] cnt,
   input logic              ld_sync,
   input logic              pad_sync,
   input logic              wait_on_done,
   input logic [CODE_W-1:0] done_code,
   input logic              done_rel,
   input logic              io_en,
   input logic              core_reset_off
);
   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |-> (!done_rel && !io_en && !core_reset_off));

   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_sync |=> $stable(cnt));

   assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != $past(cnt)) |-> (cnt == STEP_W'($past(cnt) + 1'b1)));

   assert_sticky_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_rel |=> done_rel);

   assert_sticky_io_R5: assert property (@(posedge clk) disable iff (!rst_n)
      io_en |=> io_en);

   assert_sticky_rst_R5: assert property (@(posedge clk) disable iff (!rst_n)
      core_reset_off |=> core_reset_off);

   assert_pad_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_on_done && !pad_sync &&
       (cnt >= STEP_W'(STEP_W'(done_code) + STEP_W'(2)))) |=> $stable(cnt));

   assert_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= STEP_W'(NUM_STEPS));
endmodule

bind startup_seq startup_seq_chk #(
   .NUM_STEPS(NUM_STEPS), .STEP_W(STEP_W), .CODE_W(CODE_W)
) u_chk (
   .clk           (clk_sel),
   .rst_n         (rst_n),
   .cnt           (cnt_q),
   .ld_sync       (ld_sync),
   .pad_sync      (pad_sync),
   .wait_on_done  (wait_on_done),
   .done_code     (done_step),
   .done_rel      (done_rel),
   .io_en         (io_en),
   .core_reset_off(core_reset_off)
);

// File: tb/startup_seq_tb.sv
`timescale 1ns/1ps
module startup_seq_tb;
   logic       cclk = 1'b0;
   logic       uclk = 1'b0;
   logic       rst_n = 1'b0;
   logic       use_user = 1'b0;
   logic       load_done = 1'b0;
   logic       wait_dn = 1'b0;
   logic [1:0] c_done = 2'd0;
   logic [1:0] c_io = 2'd0;
   logic [1:0] c_rst = 2'd0;
   logic       ext_hold = 1'b0;
   logic       done_rel, io_en, core_reset_off;
   logic       pad;
   logic       sclk;
   int         n_chk = 0;
   int         n_bad = 0;
   bit         finished = 1'b0;

   always #5  cclk = ~cclk;
   always #13 uclk = ~uclk;

   assign sclk = use_user ? uclk : cclk;
   assign pad  = done_rel & ~ext_hold;

   startup_seq u_dut (
      .clk_cfg       (cclk),
      .clk_user      (uclk),
      .rst_n         (rst_n),
      .use_user_clk  (use_user),
      .load_done     (load_done),
      .wait_on_done  (wait_dn),
      .done_step     (c_done),
      .io_step       (c_io),
      .rst_step      (c_rst),
      .done_pad_in   (pad),
      .done_rel      (done_rel),
      .io_en         (io_en),
      .core_reset_off(core_reset_off)
   );

   task automatic tick(input int n);
      repeat (n) @(posedge sclk);
      #2;
   endtask

   task automatic check(input logic [2:0] exp, input string req);
      n_chk++;
      if ({done_rel, io_en, core_reset_off} !== exp) begin
         n_bad++;
         $display("FAIL %s: {done,io,rst} actual=%b expected=%b at %0t",
                  req, {done_rel, io_en, core_reset_off}, exp, $time);
      end
   endtask

   task automatic restart(input logic usr, input logic wt,
                          input logic [1:0] d, input logic [1:0] i,
                          input logic [1:0] r);
      rst_n = 1'b0; load_done = 1'b0; ext_hold = 1'b0;
      use_user = usr; wait_dn = wt; c_done = d; c_io = i; c_rst = r;
      tick(2);
      rst_n = 1'b1;
      tick(1);
   endtask

   function automatic logic [2:0] expect_at(input int k, input logic [1:0] d,
                                            input logic [1:0] i, input logic [1:0] r);
      return {k > int'(d), k > int'(i), k > int'(r)};
   endfunction

   // R1: outputs low during reset
   task automatic t_reset();
      rst_n = 1'b0;
      tick(3);
      check(3'b000, "R1 reset");
   endtask

   // R2: no progress while load_done low
   task automatic t_idle();
      restart(1'b0, 1'b0, 2'd0, 2'd0, 2'd0);
      tick(8);
      check(3'b000, "R2 idle");
   endtask

   // R3 / R4: each step in turn, any order
   task automatic t_order(input logic [1:0] d, input logic [1:0] i,
                          input logic [1:0] r, input string req);
      restart(1'b0, 1'b0, d, i, r);
      load_done = 1'b1;
      tick(2);
      check(3'b000, req);
      for (int k = 1; k <= 4; k++) begin
         tick(1);
         check(expect_at(k, d, i, r), req);
      end
   endtask

   // R5: sticky after code change and load drop; then R1 mid-run reset
   task automatic t_sticky();
      c_done = 2'd3; c_io = 2'd3; c_rst = 2'd3; load_done = 1'b0;
      tick(5);
      check(3'b111, "R5 sticky");
      rst_n = 1'b0;
      #3;
      check(3'b000, "R1 midrun reset");
      rst_n = 1'b1;
   endtask

   // R6: user clock selected
   task automatic t_userclk();
      restart(1'b1, 1'b0, 2'd0, 2'd1, 2'd2);
      load_done = 1'b1;
      tick(2);
      check(3'b000, "R6 user clk sync");
      tick(1);
      check(3'b100, "R6 user clk step1");
      tick(1);
      check(3'b110, "R6 user clk step2");
      tick(1);
      check(3'b111, "R6 user clk step3");
   endtask

   // R7: stall on held pad
   task automatic t_stall();
      restart(1'b0, 1'b1, 2'd0, 2'd2, 2'd3);
      ext_hold = 1'b1;
      load_done = 1'b1;
      tick(3);
      check(3'b100, "R7 done fired");
      tick(12);
      check(3'b100, "R7 stalled");
      ext_hold = 1'b0;
      tick(2);
      check(3'b100, "R7 sync latency");
      tick(1);
      check(3'b110, "R7 resumed step3");
      tick(1);
      check(3'b111, "R7 resumed step4");
   endtask

   // R8: pad ignored without wait option
   task automatic t_nostall();
      restart(1'b0, 1'b0, 2'd0, 2'd2, 2'd3);
      ext_hold = 1'b1;
      load_done = 1'b1;
      tick(5);
      check(3'b110, "R8 no stall step3");
      tick(1);
      check(3'b111, "R8 no stall step4");
   endtask

   // R9: saturation keeps all high
   task automatic t_saturate();
      restart(1'b0, 1'b0, 2'd3, 2'd3, 2'd3);
      load_done = 1'b1;
      tick(5);
      check(3'b000, "R9 before last step");
      tick(1);
      check(3'b111, "R9 last step");
      tick(20);
      check(3'b111, "R9 saturated");
   endtask

   initial begin
      t_reset();
      t_idle();
      t_order(2'd2, 2'd0, 2'd1, "R3 order io-rst-done");
      t_order(2'd3, 2'd1, 2'd0, "R4 order rst-io-done");
      t_order(2'd1, 2'd1, 2'd1, "R4 shared step");
      t_order(2'd0, 2'd3, 2'd2, "R4 order done-rst-io");
      t_sticky();
      t_userclk();
      t_stall();
      t_nostall();
      t_saturate();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #200000;
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule